// File: doc/BRIEF.md
# Preset Down-Counter/Timer for a Dual-Channel Serial Controller

This block is the 16-bit down-counter/timer that sits inside a two-channel serial controller. Software sets the count limit through two byte-wide preset registers, one per half. The counter does not start or stop on a register write. It starts when software reads one dedicated address and stops when software reads another. The counter moves down by one on each cycle in which the prescaled `tick` input is high.

When the count runs out, a sticky `ready` flag rises. The surrounding controller shows this flag as bit 3 of its interrupt status register. Bit 2 of the mode field from the auxiliary control register selects between two behaviours. In one-shot counter mode the counter parks at zero. In periodic timer mode it reloads from the preset and keeps running. Reading the high byte of the live count also captures the low byte, so a later low-byte read returns a value that matches it.

Top module: `preset_timer`

## Requirements
- R1: After reset, `ready` is 0, the preset and count are 0, the counter is halted, and reads of address 6 and address 7 return 0.
- R2: A write at address 6 replaces only preset bits 15:8 and a write at address 7 replaces only bits 7:0. A preset write does not change the live count until the next start or periodic reload.
- R3: A read at address 14 (start) returns 0, loads the count from the preset, starts counting and clears `ready` on the next edge. Reads at addresses other than 6 and 7 return 0.
- R4: A read at address 15 (stop) returns 0, halts the counter and clears `ready`. A halted count does not change when `tick` is high.
- R5: While running, the count drops by one on each clock edge at which `tick` is 1, and holds when `tick` is 0.
- R6: With mode bit 2 = 0 (counter mode), the edge that takes the count from 1 to 0 sets `ready`. The count then stays at 0 and the counter halts. `ready` stays set, and reads of addresses 6 and 7 do not clear it.
- R7: With mode bit 2 = 1 (timer mode), the edge at which a count of 1 takes a tick sets `ready`, reloads the count from the preset and keeps the counter running. Mode bits 1:0 have no effect.
- R8: A preset of 0 gives 65536 ticks from start to expiry.
- R9: A read at address 6 returns count bits 15:8 and captures bits 7:0. A read at address 7 returns the captured byte, even if the count has moved since.
- R10: A start or stop read in the same cycle as an expiring tick wins: `ready` stays 0, and a start loads the preset again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| tick | input | 1 | Prescaled count enable |
| mode | input | 3 | Counter/timer mode field; bit 2 selects timer mode |
| rdata | output | 8 | Read data, valid in the cycle of `rd` |
| ready | output | 1 | Sticky counter-ready flag |

## Verification
Two events can land in the same cycle: a start or stop read, and the tick that would make the count expire. The directed test loads a preset of 1, starts the counter, and then issues a second start read and, later, a stop read, each together with a high `tick`. The test expects `ready` to stay low. After the start, it expects the count to show the preset again. The random phase uses small presets, frequent ticks and mixed start, stop and preset accesses, so these collisions happen many times. Each one is compared against a cycle model in the bench in which the command takes priority over expiry.

// File: rtl/preset_timer.sv
module preset_timer #(
  parameter int ADDR_W    = 4,
  parameter int BYTE_W    = 8,
  parameter int MODE_W    = 3,
  parameter int TIMER_BIT = 2,
  parameter logic [ADDR_W-1:0] A_HI   = 4'd6,
  parameter logic [ADDR_W-1:0] A_LO   = 4'd7,
  parameter logic [ADDR_W-1:0] A_GO   = 4'd14,
  parameter logic [ADDR_W-1:0] A_HALT = 4'd15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  output logic [BYTE_W-1:0] rdata,
  output logic              ready
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  preset, count;
  logic [BYTE_W-1:0] snap;
  logic              running;

  wire go     = rd && (addr == A_GO);
  wire halt   = rd && (addr == A_HALT);
  wire step   = running && tick;
  wire expire = step && (count == ONE);
  wire timer  = mode[TIMER_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset <= '0;
    end else if (wr && addr == A_HI) begin
      preset[CNT_W-1:BYTE_W] <= wdata;
    end else if (wr && addr == A_LO) begin
      preset[BYTE_W-1:0] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap <= '0;
    end else if (rd && addr == A_HI) begin
      snap <= count[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      ready   <= 1'b0;
    end else if (go) begin
      count   <= preset;
      running <= 1'b1;
      ready   <= 1'b0;
    end else if (halt) begin
      running <= 1'b0;
      ready   <= 1'b0;
    end else if (expire) begin
      ready <= 1'b1;
      if (timer) begin
        count <= preset;
      end else begin
        count   <= '0;
        running <= 1'b0;
      end
    end else if (step) begin
      count <= count - ONE;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == A_HI)      rdata = count[CNT_W-1:BYTE_W];
      else if (addr == A_LO) rdata = snap;
    end
  end
endmodule

// File: rtl/preset_timer_chk.sv
module preset_timer_chk #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  parameter logic [ADDR_W-1:0] A_GO   = 4'd14,
  parameter logic [ADDR_W-1:0] A_HALT = 4'd15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd,
  input logic              tick,
  input logic [BYTE_W-1:0] rdata,
  input logic              ready,
  input logic              running,
  input logic [2*BYTE_W-1:0] count
);
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_GO) |=> (!ready && running));

  assert_start_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_GO) |-> (rdata == '0));

  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_HALT) |=> (!ready && !running));

  assert_halted_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !(rd && addr == A_GO)) |=> $stable(count));

  assert_no_tick_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(rd && addr == A_GO)) |=> $stable(count));

  assert_ready_from_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(tick) && $past(running)));
endmodule

bind preset_timer preset_timer_chk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .A_GO(A_GO), .A_HALT(A_HALT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .tick(tick),
  .rdata(rdata), .ready(ready), .running(running), .count(count)
);

// File: tb/test_preset_timer.sv
module test_preset_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       rd, wr, tick;
  logic [7:0] wdata;
  logic [2:0] mode;
  logic [7:0] rdata;
  logic       ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_pre, m_cnt;
  logic [7:0]  m_snap;
  logic        m_run, m_rdy;

  preset_timer i_preset_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .tick(tick), .mode(mode), .rdata(rdata), .ready(ready)
  );

  always #5 clk = ~clk;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(input logic [3:0] a);
    if (a == 4'd6) return m_cnt[15:8];
    if (a == 4'd7) return m_snap;
    return 8'h00;
  endfunction

  task automatic model_step(input logic [3:0] a, input logic r, input logic w,
                            input logic [7:0] d, input logic t);
    logic [15:0] old_pre;
    old_pre = m_pre;
    if (w && a == 4'd6) m_pre[15:8] = d;
    if (w && a == 4'd7) m_pre[7:0]  = d;
    if (r && a == 4'd6) m_snap = m_cnt[7:0];
    if (r && a == 4'd14) begin
      m_cnt = old_pre; m_run = 1'b1; m_rdy = 1'b0;
    end else if (r && a == 4'd15) begin
      m_run = 1'b0; m_rdy = 1'b0;
    end else if (t && m_run) begin
      if (m_cnt == 16'd1) begin
        m_rdy = 1'b1;
        if (mode[2]) m_cnt = old_pre;
        else begin m_cnt = 16'd0; m_run = 1'b0; end
      end else begin
        m_cnt = m_cnt - 16'd1;
      end
    end
  endtask

  task automatic cyc(input logic [3:0] a, input logic r, input logic w,
                     input logic [7:0] d, input logic t, input string tag);
    addr = a; rd = r; wr = w; wdata = d; tick = t;
    #1;
    check({15'd0, ready}, {15'd0, m_rdy}, tag);
    if (r) check({8'd0, rdata}, {8'd0, exp_rdata(a)}, tag);
    @(posedge clk);
    model_step(a, r, w, d, t);
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; tick = 1'b0;
  endtask

  task automatic wr_pre(input logic [15:0] v, input string tag);
    cyc(4'd6, 1'b0, 1'b1, v[15:8], 1'b0, tag);
    cyc(4'd7, 1'b0, 1'b1, v[7:0], 1'b0, tag);
  endtask

  task automatic read_cnt(output logic [15:0] v, input string tag);
    logic [7:0] hi;
    addr = 4'd6; rd = 1'b1; #1; hi = rdata;
    rd = 1'b0; #1;
    cyc(4'd6, 1'b1, 1'b0, 8'h00, 1'b0, tag);
    addr = 4'd7; rd = 1'b1; #1;
    v = {hi, rdata};
    rd = 1'b0;
    cyc(4'd7, 1'b1, 1'b0, 8'h00, 1'b0, tag);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; addr = '0; rd = 0; wr = 0; wdata = '0; tick = 0; mode = 3'b000;
    m_pre = '0; m_cnt = '0; m_snap = '0; m_run = 0; m_rdy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    check({15'd0, ready}, 16'd0, "R1");
    read_cnt(v, "R1");
    check(v, 16'h0000, "R1");

    // R2 bytewise preset
    wr_pre(16'h1234, "R2");
    cyc(4'd6, 1'b0, 1'b1, 8'hAB, 1'b0, "R2");
    cyc(4'd14, 1'b1, 1'b0, 8'h00, 1'b0, "R3");
    read_cnt(v, "R2");
    check(v, 16'hAB34, "R2");
    wr_pre(16'h0099, "R2");
    read_cnt(v, "R2");
    check(v, 16'hAB34, "R2");

    // R5 counting only on tick
    repeat (3) cyc(4'd0, 1'b0, 1'b0, 8'h00, 1'b0, "R5");
    repeat (5) cyc(4'd0, 1'b0, 1'b0, 8'h00, 1'b1, "R5");
    read_cnt(v, "R5");
    check(v, 16'hAB2F, "R5");

    // R4 stop halts
    cyc(4'd15, 1'b1, 1'b0, 8'h00, 1'b0, "R4");
    repeat (4) cyc(4'd0, 1'b0, 1'b0, 8'h00, 1'b1, "R4");
    read_cnt(v, "R4");
    check(v, 16'hAB2F, "R4");
    cyc(4'd9, 1'b1, 1'b0, 8'h00, 1'b0, "R3");

    // R6 counter mode one-shot
    mode = 3'b011;
    wr_pre(16'h0003, "R6");
    cyc(4'd14, 1'b1, 1'b0, 8'h00, 1'b0, "R6");
    repeat (3) cyc(4'd0, 1'b0, 1'b0, 8'h00, 1'b1, "R6");
    check({15'd0, ready}, 16'd1, "R6");
    repeat (3) cyc(4'd0, 1'b0, 1'b0, 8'h00, 1'b1, "R6");
    read_cnt(v, "R6");
    check(v, 16'h0000, "R6");
    check({15'd0, ready}, 16'd1, "R6");
    cyc(4'd15, 1'b1, 1'b0, 8'h00, 1'b0, "R4");
    check({15'd0, ready}, 16'd0, "R4");

    // R7 timer mode periodic
    mode = 3'b100;
    wr_pre(16'h0002, "R7");
    cyc(4'd14, 1'b1, 1'b0, 8'h00, 1'b0, "R7");
    repeat (2) cyc(4'd0, 1'b0, 1'b0, 8'h00, 1'b1, "R7");
    check({15'd0, ready}, 16'd1, "R7");
    read_cnt(v, "R7");
    check(v, 16'h0002, "R7");
    cyc(4'd0, 1'b0, 1'b0, 8'h00, 1'b1, "R7");
    read_cnt(v, "R7");
    check(v, 16'h0001, "R7");

    // R10 command beats expiry
    mode = 3'b000;
    wr_pre(16'h0001, "R10");
    cyc(4'd14, 1'b1, 1'b0, 8'h00, 1'b0, "R10");
    cyc(4'd14, 1'b1, 1'b0, 8'h00, 1'b1, "R10");
    check({15'd0, ready}, 16'd0, "R10");
    read_cnt(v, "R10");
    check(v, 16'h0001, "R10");
    cyc(4'd15, 1'b1, 1'b0, 8'h00, 1'b1, "R10");
    check({15'd0, ready}, 16'd0, "R10");

    // R9 consistent snapshot
    wr_pre(16'h0100, "R9");
    cyc(4'd14, 1'b1, 1'b0, 8'h00, 1'b0, "R9");
    cyc(4'd6, 1'b1, 1'b0, 8'h00, 1'b1, "R9");
    addr = 4'd7; rd = 1'b1; #1;
    check({8'd0, rdata}, 16'h0000, "R9");
    rd = 1'b0;
    read_cnt(v, "R9");
    check(v, 16'h00FF, "R9");

    // R8 preset zero means 65536 ticks
    wr_pre(16'h0000, "R8");
    cyc(4'd14, 1'b1, 1'b0, 8'h00, 1'b0, "R8");
    for (int i = 0; i < 65535; i++) cyc(4'd0, 1'b0, 1'b0, 8'h00, 1'b1, "R8");
    check({15'd0, ready}, 16'd0, "R8");
    read_cnt(v, "R8");
    check(v, 16'h0001, "R8");
    cyc(4'd0, 1'b0, 1'b0, 8'h00, 1'b1, "R8");
    check({15'd0, ready}, 16'd1, "R8");

    // Random mix, R5 R6 R7 R10 against the model
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      int sel;
      if (i % 250 == 0) mode = 3'($urandom);
      sel = $urandom % 10;
      a = (sel < 3) ? 4'd6 : (sel < 5) ? 4'd7 : (sel < 7) ? 4'd14 : (sel < 8) ? 4'd15 : 4'($urandom);
      d = (a == 4'd6) ? 8'($urandom % 2) : 8'($urandom % 8);
      sel = $urandom % 4;
      cyc(a, sel == 1, sel == 2, d, 1'($urandom % 3 != 0), "R7");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule